// File: doc/BRIEF.md
# Serial-Loaded Switch Enable Register with Hold Stage and Cascade Output

This block is the digital control core of a multi-channel switch array. A host streams one bit per qualified clock into a serial shift chain. A hold stage sits between the chain and the switch-enable outputs. While `hold` is low, the hold stage follows the chain. While `hold` is high, it keeps the last value it captured, so the host can shift a new frame in without disturbing the switches. The last stage of the chain comes out on `dout`, so several of these blocks can be cascaded into one longer chain.

A clear input forces every enable line off at once. It does not touch the shift chain or the held word. When clear is released with `hold` still high, the held word appears on the outputs again. The whole block lives in one synchronous clock domain. A rising edge of the serial clock is represented by `shift_en` being high at a rising edge of `clk`.

Top module: `sw_ctl_core`

## Requirements
- R1: At a `clk` edge with `shift_en`=1, stage 0 takes `sdi` and stage n+1 takes the old stage n. With `shift_en`=0, the chain keeps its contents.
- R2: `dout` equals the top stage (stage NUM_CH-1) of the chain. It changes only after a `clk` edge at which `shift_en` was 1.
- R3: If `hold` is 0 at a `clk` edge, then after that edge `sw_en` shows the chain contents as they stand after the edge (provided `clr` is 0).
- R4: If `hold` is 1 at a `clk` edge, the held word does not change, whatever shifting happens at that edge.
- R5: While `clr` is 1, `sw_en` is all zeros in the same cycle, whatever the other inputs are.
- R6: `clr` does not change the chain or the held word. After `clr` returns to 0 with `hold` high, `sw_en` shows the word held before the clear.
- R7: A `clk` edge with `rst`=1 sets the chain and the held word to zero. `sw_en` and `dout` then read 0.
- R8: Bit n of `sw_en` drives switch n, and 1 means on. The first bit shifted in of an NUM_CH-bit frame ends in stage NUM_CH-1. So word W is loaded by sending W[NUM_CH-1] first and W[0] last.
- R9: When `dout` of one block feeds `sdi` of the next, and both share `shift_en`, 2*NUM_CH shifts load both blocks. The first NUM_CH bits sent end up in the far block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data in |
| shift_en | input | 1 | Qualifies a clock edge as a serial shift |
| hold | input | 1 | High: hold stage keeps its word; low: follows the chain |
| clr | input | 1 | Forces all enables off |
| sw_en | output | NUM_CH | Switch enable lines, 1 = on |
| dout | output | 1 | Top chain stage, for cascading |

## Verification
The bench builds two instances with NUM_CH=16 and joins them through `dout`. This makes the 32-bit cascade, and the moment a bit crosses from one chain into the next, reachable. The width of 16 lets the bench load whole frames with full-width patterns. This shows that the bit order and the position of every channel are right. It also runs a clear while shifting under hold, so the retained chain can be seen afterwards through `dout` and the restored outputs.

// File: rtl/sw_ctl_pkg.sv
package sw_ctl_pkg;
    localparam int DEF_CH = 16;

    // one cycle of serial control presented to the chain and hold stage
    typedef struct packed {
        logic shift;
        logic data;
        logic hold;
        logic clr;
    } ctl_t;

    function automatic logic gate_bit(input logic en, input logic clr);
        return en & ~clr;
    endfunction
endpackage

// File: rtl/sw_shift_chain.sv
module sw_shift_chain #(
    parameter int NUM_CH = sw_ctl_pkg::DEF_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic              sdi,
    output logic [NUM_CH-1:0] q,
    output logic [NUM_CH-1:0] q_next
);
    localparam int TOP = NUM_CH - 1;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign q_next[g] = shift ? sdi : q[g];
        end else begin : g_body
            assign q_next[g] = shift ? q[g-1] : q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

    p_chain_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(q));
    p_chain_entry_r1: assert property (@(posedge clk) disable iff (rst)
        shift |=> (q[0] == $past(sdi)));
    p_chain_top_r1: assert property (@(posedge clk) disable iff (rst)
        shift |=> (q[TOP] == $past(q[TOP-1])));
endmodule

// File: rtl/sw_hold_latch.sv
module sw_hold_latch #(
    parameter int NUM_CH = sw_ctl_pkg::DEF_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [NUM_CH-1:0] d,
    output logic [NUM_CH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (!hold) q <= d;
    end

    p_hold_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(q));
endmodule

// File: rtl/sw_clear_gate.sv
module sw_clear_gate #(
    parameter int NUM_CH = sw_ctl_pkg::DEF_CH
) (
    input  logic              clr,
    input  logic [NUM_CH-1:0] d,
    output logic [NUM_CH-1:0] y
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign y[g] = sw_ctl_pkg::gate_bit(d[g], clr);
    end
endmodule

// File: rtl/sw_ctl_core.sv
module sw_ctl_core #(
    parameter int NUM_CH = sw_ctl_pkg::DEF_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi,
    input  logic              shift_en,
    input  logic              hold,
    input  logic              clr,
    output logic [NUM_CH-1:0] sw_en,
    output logic              dout
);
    import sw_ctl_pkg::*;

    localparam int TOP = NUM_CH - 1;

    ctl_t              ctl;
    logic [NUM_CH-1:0] chain_q;
    logic [NUM_CH-1:0] chain_next;
    logic [NUM_CH-1:0] held_q;

    assign ctl = '{shift: shift_en, data: sdi, hold: hold, clr: clr};

    sw_shift_chain #(.NUM_CH(NUM_CH)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .shift  (ctl.shift),
        .sdi    (ctl.data),
        .q      (chain_q),
        .q_next (chain_next)
    );

    sw_hold_latch #(.NUM_CH(NUM_CH)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .hold (ctl.hold),
        .d    (chain_next),
        .q    (held_q)
    );

    sw_clear_gate #(.NUM_CH(NUM_CH)) u_gate (
        .clr (ctl.clr),
        .d   (held_q),
        .y   (sw_en)
    );

    assign dout = chain_q[TOP];

    p_track_chain_r3: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (held_q == chain_q));
    p_dout_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(dout));
    p_clear_off_r5: assert property (@(posedge clk) disable iff (rst)
        clr |-> (sw_en == '0));
    p_clear_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (clr && hold) |=> (held_q == $past(held_q)));
    p_reset_zero_r7: assert property (@(posedge clk)
        $past(rst) |-> ((sw_en == '0) && !dout));
endmodule

// File: tb/sw_ctl_core_test.sv
module sw_ctl_core_test;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sdi = 1'b0;
    logic         shift_en = 1'b0;
    logic         hold = 1'b0;
    logic         clr = 1'b0;
    logic [N-1:0] sw_a, sw_b;
    logic         dout_a, dout_b;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [N-1:0] sa;
        logic [N-1:0] sb;
        logic         da;
        logic         db;
        string        req;
    } exp_t;

    exp_t sbq[$];

    logic [N-1:0] m_sra = '0, m_sla = '0, m_srb = '0, m_slb = '0;

    always #5 clk = ~clk;

    sw_ctl_core #(.NUM_CH(N)) uut (
        .clk(clk), .rst(rst), .sdi(sdi), .shift_en(shift_en),
        .hold(hold), .clr(clr), .sw_en(sw_a), .dout(dout_a)
    );

    sw_ctl_core #(.NUM_CH(N)) uut_b (
        .clk(clk), .rst(rst), .sdi(dout_a), .shift_en(shift_en),
        .hold(hold), .clr(clr), .sw_en(sw_b), .dout(dout_b)
    );

    // driver: present one cycle of stimulus, predict the state after the edge
    task automatic step(input logic r, input logic d, input logic sh,
                        input logic h, input logic c, input string req);
        exp_t e;
        logic carry;
        rst = r; sdi = d; shift_en = sh; hold = h; clr = c;
        if (r) begin
            m_sra = '0; m_sla = '0; m_srb = '0; m_slb = '0;
        end else begin
            if (sh) begin
                carry = m_sra[N-1];
                m_sra = {m_sra[N-2:0], d};
                m_srb = {m_srb[N-2:0], carry};
            end
            if (!h) begin
                m_sla = m_sra;
                m_slb = m_srb;
            end
        end
        e.sa = c ? '0 : m_sla;
        e.sb = c ? '0 : m_slb;
        e.da = m_sra[N-1];
        e.db = m_srb[N-1];
        e.req = req;
        sbq.push_back(e);
        @(posedge clk);
        #4;
    endtask

    task automatic load(input logic [N-1:0] w, input logic h, input logic c,
                        input string req);
        for (int i = N - 1; i >= 0; i--) step(1'b0, w[i], 1'b1, h, c, req);
    endtask

    // monitor: compare after each edge, away from it
    always @(posedge clk) begin
        #2;
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            n_cmp++;
            if (sw_a !== e.sa || sw_b !== e.sb || dout_a !== e.da || dout_b !== e.db) begin
                n_bad++;
                $display("FAIL %s: sw_a=%h sw_b=%h da=%b db=%b expected sw_a=%h sw_b=%h da=%b db=%b",
                         e.req, sw_a, sw_b, dout_a, dout_b, e.sa, e.sb, e.da, e.db);
            end
        end
    end

    task automatic direct(input logic ok, input string req, input logic [N-1:0] act,
                          input logic [N-1:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R7: reset state
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        // R1/R3/R8: load a frame with the hold stage following
        load(16'hA5C3, 1'b0, 1'b0, "R3");
        direct(sw_a == 16'hA5C3, "R8", sw_a, 16'hA5C3);
        // R1: idle cycles keep the chain
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        // R4/R2: shift a new frame under hold
        load(16'h3C0F, 1'b1, 1'b0, "R4");
        direct(sw_a == 16'hA5C3, "R4", sw_a, 16'hA5C3);
        // R5: clear while shifting under hold
        for (int i = 0; i < 5; i++) step(1'b0, i[0], 1'b1, 1'b1, 1'b1, "R5");
        // R6: release clear, held word returns; chain untouched
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
        direct(sw_a == 16'hA5C3, "R6", sw_a, 16'hA5C3);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
        // R3: drop hold, outputs show chain
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        // R5: clear with hold low
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
        // R9: cascade load of 32 bits, far word first
        load(16'h8421, 1'b0, 1'b0, "R9");
        load(16'h7E18, 1'b0, 1'b0, "R9");
        direct(sw_b == 16'h8421, "R9", sw_b, 16'h8421);
        direct(sw_a == 16'h7E18, "R9", sw_a, 16'h7E18);
        // R7: reset mid-stream
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        #10;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule